// File: doc/BRIEF.md
# Task-Switch Gate and Nesting Controller

This unit decides whether a requested hardware task switch may go ahead. It also works out how the bookkeeping of the old task and the new task must change. Its inputs are:

- the kind of transfer that asked for the switch;
- whether the transfer goes through a task gate;
- the current privilege level, the requested privilege level of the gate selector and the gate's privilege level;
- the long-mode flag;
- the upper descriptor doublewords of the current and target task-state segments;
- the current nested-task flag, link selector and own selector.

From these it produces a pass/fault verdict with one fault code. It also produces the selector of the task to enter and write enables with values for the busy bits, the nested-task flags and the new task's link field.

The block only decides. The memory writes and the saving and loading of task state belong to the surrounding sequencer. That sequencer pulses a request, reads the registered verdict one cycle later, and applies only the writes whose enables are high.

Top module: `task_switch_ctl`

## Requirements
- R1: A request on `req_i` is answered by `done_o` high for exactly the next cycle, with all results registered. While `done_o` is low, `switch_o`, `fault_o` and every write enable are low.
- R2: A transfer through a gate passes only when CPL ≤ gate DPL and RPL ≤ gate DPL. Failing either comparison gives fault code 2. The target descriptor's own DPL (`tss_dpl_i`) has no effect on the result.
- R3: A gate transfer while `long_mode_i` is 1 gives fault code 1. This fault outranks every other fault.
- R4: For JMP (kind 0), the target is `tgt_sel_i`. The old busy bit is written to 0 and the new busy bit is written to 1. NT and the link field are not written.
- R5: For CALL (1), software INTn (2), interrupt (3) and exception (4), the target is `tgt_sel_i` and the new busy bit is written to 1. The new task's NT is written to 1 and its link field is written with `cur_sel_i`. The old busy bit is not written.
- R6: For kinds 0 to 4, a target whose busy bit is set gives fault code 3. This fault ranks below codes 1 and 2.
- R7: IRET (kind 5) with `cur_nt_i`=1 switches to the task named by `cur_link_i`. The old NT is written to 0 and the old busy bit is written to 0. The new busy bit is not written, and the target's busy state is not checked.
- R8: IRET with `cur_nt_i`=0 reports no switch and no fault, with code 0 and all enables low.
- R9: The busy flag is bit 9 of the descriptor doubleword at offset +4. `new_desc_o` equals `tgt_desc_i` with bit 9 set, and `old_desc_o` equals `cur_desc_i` with bit 9 cleared. No other bit changes.
- R10: On any fault, `fault_o` is high, `switch_o` is low and every write enable is low. Fault codes are 0 for none, 1 for long mode, 2 for privilege and 3 for a busy target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| kind_i | input | 3 | Initiator: 0 JMP, 1 CALL, 2 INTn, 3 interrupt, 4 exception, 5 IRET |
| via_gate_i | input | 1 | Transfer goes through a task gate |
| long_mode_i | input | 1 | Long mode active |
| cpl_i | input | 2 | Current privilege level |
| rpl_i | input | 2 | Gate selector RPL |
| gate_dpl_i | input | 2 | Gate DPL |
| tss_dpl_i | input | 2 | Target descriptor DPL (not consulted) |
| tgt_sel_i | input | 16 | Target selector from the gate or operand |
| cur_sel_i | input | 16 | Selector of the current task |
| cur_link_i | input | 16 | Link field of the current task |
| cur_nt_i | input | 1 | Current nested-task flag |
| tgt_desc_i | input | 32 | Target descriptor upper doubleword |
| cur_desc_i | input | 32 | Current descriptor upper doubleword |
| done_o | output | 1 | Result valid |
| switch_o | output | 1 | Task switch proceeds |
| fault_o | output | 1 | General-protection fault |
| fault_code_o | output | 2 | Fault cause |
| new_sel_o | output | 16 | Selector of the task to enter |
| old_busy_we_o | output | 1 | Write `old_desc_o` |
| old_desc_o | output | 32 | Current descriptor with busy cleared |
| new_busy_we_o | output | 1 | Write `new_desc_o` |
| new_desc_o | output | 32 | Target descriptor with busy set |
| old_nt_we_o | output | 1 | Clear the old task's NT |
| new_nt_we_o | output | 1 | Set the new task's NT |
| new_link_we_o | output | 1 | Write `new_link_o` into the new task's link field |
| new_link_o | output | 16 | Link value for the new task |

## Verification
The three fault causes can all be true in the same request, and the reported code must follow the ranking.

The vector table provokes these collisions directly:
- long mode together with a failed privilege check and a busy target;
- a failed privilege check together with a busy target;
- an IRET whose target is busy, which must still switch.

Each vector is judged on the single fault code. It is also judged on the complete set of enables and selector values, taken one cycle after the strobe.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  typedef enum logic [2:0] {
    K_JMP  = 3'd0,
    K_CALL = 3'd1,
    K_INTN = 3'd2,
    K_INTR = 3'd3,
    K_EXC  = 3'd4,
    K_IRET = 3'd5
  } kind_e;

  typedef enum logic [1:0] {
    F_NONE = 2'd0,
    F_LONG = 2'd1,
    F_PRIV = 2'd2,
    F_BUSY = 2'd3
  } fcode_e;
endpackage

// File: rtl/tsw_priv_chk.sv
module tsw_priv_chk #(
  parameter int unsigned PL_W = 2
) (
  input  logic            via_gate_i,
  input  logic            long_mode_i,
  input  logic [PL_W-1:0] cpl_i,
  input  logic [PL_W-1:0] rpl_i,
  input  logic [PL_W-1:0] gate_dpl_i,
  output logic            lm_fault_o,
  output logic            priv_fault_o
);
  logic cpl_ok, rpl_ok;

  always_comb begin
    cpl_ok       = cpl_i <= gate_dpl_i;
    rpl_ok       = rpl_i <= gate_dpl_i;
    lm_fault_o   = via_gate_i & long_mode_i;
    priv_fault_o = via_gate_i & ~(cpl_ok & rpl_ok);
  end
endmodule

// File: rtl/tsw_nest_rules.sv
module tsw_nest_rules
  import tsw_pkg::*;
(
  input  logic [2:0] kind_i,
  input  logic       cur_nt_i,
  output logic       switch_o,
  output logic       busy_chk_o,
  output logic       from_link_o,
  output logic       old_busy_we_o,
  output logic       new_busy_we_o,
  output logic       old_nt_we_o,
  output logic       new_nt_we_o,
  output logic       link_we_o
);
  always_comb begin
    switch_o      = 1'b0;
    busy_chk_o    = 1'b0;
    from_link_o   = 1'b0;
    old_busy_we_o = 1'b0;
    new_busy_we_o = 1'b0;
    old_nt_we_o   = 1'b0;
    new_nt_we_o   = 1'b0;
    link_we_o     = 1'b0;
    unique case (kind_i)
      K_JMP: begin
        switch_o      = 1'b1;
        busy_chk_o    = 1'b1;
        old_busy_we_o = 1'b1;
        new_busy_we_o = 1'b1;
      end
      K_CALL, K_INTN, K_INTR, K_EXC: begin
        switch_o      = 1'b1;
        busy_chk_o    = 1'b1;
        new_busy_we_o = 1'b1;
        new_nt_we_o   = 1'b1;
        link_we_o     = 1'b1;
      end
      K_IRET: begin
        // no switch without nesting
        switch_o      = cur_nt_i;
        from_link_o   = 1'b1;
        old_busy_we_o = cur_nt_i;
        old_nt_we_o   = cur_nt_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/task_switch_ctl.sv
module task_switch_ctl
  import tsw_pkg::*;
#(
  parameter int unsigned SEL_W    = 16,
  parameter int unsigned DESC_W   = 32,
  parameter int unsigned BUSY_BIT = 9,
  parameter int unsigned PL_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        kind_i,
  input  logic              via_gate_i,
  input  logic              long_mode_i,
  input  logic [PL_W-1:0]   cpl_i,
  input  logic [PL_W-1:0]   rpl_i,
  input  logic [PL_W-1:0]   gate_dpl_i,
  input  logic [PL_W-1:0]   tss_dpl_i,
  input  logic [SEL_W-1:0]  tgt_sel_i,
  input  logic [SEL_W-1:0]  cur_sel_i,
  input  logic [SEL_W-1:0]  cur_link_i,
  input  logic              cur_nt_i,
  input  logic [DESC_W-1:0] tgt_desc_i,
  input  logic [DESC_W-1:0] cur_desc_i,
  output logic              done_o,
  output logic              switch_o,
  output logic              fault_o,
  output logic [1:0]        fault_code_o,
  output logic [SEL_W-1:0]  new_sel_o,
  output logic              old_busy_we_o,
  output logic [DESC_W-1:0] old_desc_o,
  output logic              new_busy_we_o,
  output logic [DESC_W-1:0] new_desc_o,
  output logic              old_nt_we_o,
  output logic              new_nt_we_o,
  output logic              new_link_we_o,
  output logic [SEL_W-1:0]  new_link_o
);
  localparam logic [DESC_W-1:0] BUSY_MASK = DESC_W'(1) << BUSY_BIT;

  logic lm_f, priv_f, busy_f, any_f;
  logic r_sw, r_chk, r_link, r_obwe, r_nbwe, r_ontwe, r_nntwe, r_lwe;
  fcode_e code;
  logic unused_dpl;

  assign unused_dpl = ^tss_dpl_i;  // never consulted for gate transfers

  tsw_priv_chk #(.PL_W(PL_W)) u_priv (
    .via_gate_i  (via_gate_i),
    .long_mode_i (long_mode_i),
    .cpl_i       (cpl_i),
    .rpl_i       (rpl_i),
    .gate_dpl_i  (gate_dpl_i),
    .lm_fault_o  (lm_f),
    .priv_fault_o(priv_f)
  );

  tsw_nest_rules u_rules (
    .kind_i       (kind_i),
    .cur_nt_i     (cur_nt_i),
    .switch_o     (r_sw),
    .busy_chk_o   (r_chk),
    .from_link_o  (r_link),
    .old_busy_we_o(r_obwe),
    .new_busy_we_o(r_nbwe),
    .old_nt_we_o  (r_ontwe),
    .new_nt_we_o  (r_nntwe),
    .link_we_o    (r_lwe)
  );

  always_comb begin
    busy_f = r_chk & tgt_desc_i[BUSY_BIT];
    if (lm_f)        code = F_LONG;
    else if (priv_f) code = F_PRIV;
    else if (busy_f) code = F_BUSY;
    else             code = F_NONE;
    any_f = code != F_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o        <= 1'b0;
      switch_o      <= 1'b0;
      fault_o       <= 1'b0;
      fault_code_o  <= 2'd0;
      new_sel_o     <= '0;
      old_busy_we_o <= 1'b0;
      old_desc_o    <= '0;
      new_busy_we_o <= 1'b0;
      new_desc_o    <= '0;
      old_nt_we_o   <= 1'b0;
      new_nt_we_o   <= 1'b0;
      new_link_we_o <= 1'b0;
      new_link_o    <= '0;
    end else begin
      done_o        <= req_i;
      switch_o      <= req_i & r_sw & ~any_f;
      fault_o       <= req_i & any_f;
      old_busy_we_o <= req_i & r_sw & ~any_f & r_obwe;
      new_busy_we_o <= req_i & r_sw & ~any_f & r_nbwe;
      old_nt_we_o   <= req_i & r_sw & ~any_f & r_ontwe;
      new_nt_we_o   <= req_i & r_sw & ~any_f & r_nntwe;
      new_link_we_o <= req_i & r_sw & ~any_f & r_lwe;
      if (req_i) begin
        fault_code_o <= code;
        new_sel_o    <= r_link ? cur_link_i : tgt_sel_i;
        old_desc_o   <= cur_desc_i & ~BUSY_MASK;
        new_desc_o   <= tgt_desc_i | BUSY_MASK;
        new_link_o   <= cur_sel_i;
      end
    end
  end

  // R1
  done_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(switch_o | fault_o | old_busy_we_o | new_busy_we_o |
                  old_nt_we_o | new_nt_we_o | new_link_we_o));
  // R10
  fault_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !(switch_o | old_busy_we_o | new_busy_we_o |
                  old_nt_we_o | new_nt_we_o | new_link_we_o));
  // R3
  lm_fault_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_code_o == F_LONG) |-> $past(long_mode_i));
  // R6
  busy_fault_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_code_o == F_BUSY) |-> $past(tgt_desc_i[BUSY_BIT]));
  // R5
  nest_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_link_we_o |-> (new_nt_we_o && new_busy_we_o && !old_busy_we_o));
  // R7
  iret_unnest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    old_nt_we_o |-> (old_busy_we_o && !new_busy_we_o && !new_link_we_o));
endmodule

// File: tb/sim_task_switch_ctl.sv
`timescale 1ns/1ps
module sim_task_switch_ctl;
  typedef struct packed {
    logic [2:0] kind;
    logic       gate;
    logic       lm;
    logic [1:0] cpl;
    logic [1:0] rpl;
    logic [1:0] gdpl;
    logic [1:0] tdpl;
    logic       nt;
    logic       tbusy;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0}, // R4 plain jmp
    '{3'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1}, // R6 jmp busy
    '{3'd1, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd3, 1'b0, 1'b0}, // R5 call ok
    '{3'd1, 1'b1, 1'b0, 2'd2, 2'd3, 2'd3, 2'd0, 1'b0, 1'b0}, // R2 tss dpl ignored
    '{3'd1, 1'b1, 1'b0, 2'd2, 2'd3, 2'd0, 2'd3, 1'b0, 1'b0}, // R2 both fail
    '{3'd2, 1'b1, 1'b0, 2'd3, 2'd0, 2'd2, 2'd3, 1'b0, 1'b0}, // R2 cpl fails
    '{3'd2, 1'b1, 1'b0, 2'd1, 2'd3, 2'd2, 2'd3, 1'b0, 1'b0}, // R2 rpl fails
    '{3'd3, 1'b1, 1'b1, 2'd3, 2'd3, 2'd0, 2'd0, 1'b0, 1'b1}, // R3 all faults
    '{3'd4, 1'b1, 1'b0, 2'd3, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1}, // R6 priv over busy
    '{3'd4, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0}, // R5 exception
    '{3'd5, 1'b0, 1'b0, 2'd3, 2'd3, 2'd0, 2'd0, 1'b1, 1'b1}, // R7 iret busy tgt
    '{3'd5, 1'b0, 1'b0, 2'd3, 2'd3, 2'd0, 2'd0, 1'b0, 1'b0}, // R8 iret nt0
    '{3'd0, 1'b1, 1'b1, 2'd0, 2'd0, 2'd3, 2'd0, 1'b0, 1'b0}, // R3 jmp gate lm
    '{3'd1, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0}, // R3 no gate in lm
    '{3'd3, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1}  // R6 intr busy
  };

  localparam logic [15:0] TSEL = 16'h0028, CSEL = 16'h0030, LSEL = 16'h0048;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [2:0] kind = '0;
  logic gate = 0, lm = 0, nt = 0;
  logic [1:0] cpl = 0, rpl = 0, gdpl = 0, tdpl = 0;
  logic [31:0] tdesc = 32'h0000_8900, cdesc = 32'h0000_8B00;
  logic done, sw, flt, obwe, nbwe, ontwe, nntwe, lwe;
  logic [1:0] code;
  logic [15:0] nsel, nlink;
  logic [31:0] odesc, ndesc;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  task_switch_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .via_gate_i(gate),
    .long_mode_i(lm), .cpl_i(cpl), .rpl_i(rpl), .gate_dpl_i(gdpl), .tss_dpl_i(tdpl),
    .tgt_sel_i(TSEL), .cur_sel_i(CSEL), .cur_link_i(LSEL), .cur_nt_i(nt),
    .tgt_desc_i(tdesc), .cur_desc_i(cdesc), .done_o(done), .switch_o(sw),
    .fault_o(flt), .fault_code_o(code), .new_sel_o(nsel), .old_busy_we_o(obwe),
    .old_desc_o(odesc), .new_busy_we_o(nbwe), .new_desc_o(ndesc),
    .old_nt_we_o(ontwe), .new_nt_we_o(nntwe), .new_link_we_o(lwe), .new_link_o(nlink)
  );

  typedef struct packed {
    logic sw; logic flt; logic [1:0] code; logic [15:0] sel;
    logic obwe; logic [31:0] od; logic nbwe; logic [31:0] nd;
    logic ontwe; logic nntwe; logic lwe; logic [15:0] link;
  } res_t;

  function automatic res_t expect_of(vec_t v, logic [31:0] td, logic [31:0] cd);
    res_t r;
    logic ok;
    r = '0;
    r.sel  = (v.kind == 3'd5) ? LSEL : TSEL;
    r.od   = cd & ~(32'd1 << 9);  // R9
    r.nd   = td | (32'd1 << 9);
    r.link = CSEL;
    if (v.gate && v.lm) r.code = 2'd1;
    else if (v.gate && (v.cpl > v.gdpl || v.rpl > v.gdpl)) r.code = 2'd2;
    else if (v.kind != 3'd5 && td[9]) r.code = 2'd3;
    r.flt = r.code != 2'd0;
    ok = !r.flt && (v.kind != 3'd5 || v.nt);
    r.sw = ok;
    if (ok) begin
      case (v.kind)
        3'd0: begin r.obwe = 1; r.nbwe = 1; end
        3'd5: begin r.obwe = 1; r.ontwe = 1; end
        default: begin r.nbwe = 1; r.nntwe = 1; r.lwe = 1; end
      endcase
    end
    return r;
  endfunction

  function automatic res_t actual();
    return '{sw, flt, code, nsel, obwe, odesc, nbwe, ndesc, ontwe, nntwe, lwe, nlink};
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(vec_t v, string tag);
    res_t e;
    @(negedge clk);
    kind = v.kind; gate = v.gate; lm = v.lm; cpl = v.cpl; rpl = v.rpl;
    gdpl = v.gdpl; tdpl = v.tdpl; nt = v.nt;
    tdesc[9] = v.tbusy;
    req = 1'b1;
    e = expect_of(v, tdesc, cdesc);
    @(negedge clk);
    req = 1'b0;
    check({tag, " done"}, 128'(done), 128'd1);  // R1
    check(tag, 128'(actual()), 128'(e));
  endtask

  initial begin : watchdog
    #100000;
    fails++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // reset state (R1)
    #1;
    check("R1 reset", 128'({done, sw, flt, obwe, nbwe, ontwe, nntwe, lwe}), 128'd0);
    #11 rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run(VECS[i], $sformatf("vec%0d", i));

    // R1: idle cycle after a request drops result and enables
    @(negedge clk);
    check("R1 idle", 128'({done, sw, flt, obwe, nbwe, ontwe, nntwe, lwe}), 128'd0);

    // R9: only bit 9 touched in both descriptor words
    tdesc = 32'hFFFF_FDFF; cdesc = 32'hFFFF_FFFF;
    begin
      vec_t v;
      v = '{3'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0};
      run(v, "R9 jmp");
      check("R9 new_desc", 128'(ndesc), 128'(32'hFFFF_FFFF));
      check("R9 old_desc", 128'(odesc), 128'(32'hFFFF_FDFF));
      // R10: busy fault on the same word raises no write
      v.tbusy = 1'b1;
      run(v, "R10 busy");
      check("R10 enables", 128'({sw, obwe, nbwe, ontwe, nntwe, lwe}), 128'd0);
    end

    // R8: back-to-back iret with nt=0 stays silent
    begin
      vec_t v;
      v = '{3'd5, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0};
      run(v, "R8 iret");
      check("R8 quiet", 128'({sw, flt, code, obwe, nbwe, ontwe, nntwe, lwe}), 128'd0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule